// File: doc/BRIEF.md
# Binary to Base-100 Digit Converter

This block turns an unsigned binary operand into a row of base-100 digits. Each digit is a 7-bit binary number from 0 to 99, which suits a display stage that shows two decimal places per digit. With the default parameters the operand is 26 bits and the result is four digits, which covers every 26-bit value up to 67,108,863.

The conversion is serial. A chain of digit cells sits to the left of the operand shift register, and on every shifting cycle the operand's top bit moves into the lowest cell. Before each shift, any cell that holds 50 or more has 14 added to it. After one shift per operand bit, the cells hold the base-100 result.

A small controller runs the sequence. It waits for the start input to go low and then high. It then clears every register and waits until they all read zero. Next it loads the operand and shifts for a bit count set by a down-counter. At the end it raises done and holds the digits until the next accepted start.

Top module: `b100_conv`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 1, digits_o is 0, count_o is 0, and state_o is 0. The state encoding is idle=0, armed=1, clearing=2, loading=3, shifting=4.
- R2: When a conversion finishes, digits_o holds the base-100 form of the operand that was loaded. The most significant digit is in bits [27:21] and the least significant digit is in bits [6:0]. For example, 11347559 gives 11, 34, 75, 59.
- R3: Before each shift, a digit cell holding a value of 50 or more has 14 added to it. No digit cell ever holds a value above 99.
- R4: A conversion starts only after start_i has been sampled low while idle and then sampled high while armed. If start_i is held high with no low phase, nothing starts.
- R5: The clearing phase lasts 1 cycle when every register already reads zero, and 2 cycles otherwise. The operand is loaded only after all registers read zero.
- R6: The bit counter is set to 25 while clearing and counts down by one in each shifting cycle, for exactly 26 shifts. It holds at 0, and count_o is 0 whenever done_o is high.
- R7: done_o is 1 in the idle and armed states and 0 from the cycle after start is accepted until the conversion ends. The whole busy span is 27 cycles plus the clearing length.
- R8: Start edges that arrive while a conversion is running are ignored. They neither restart nor lengthen the conversion.
- R9: While done_o is high, digits_o does not change, even when value_i changes.
- R10: In the operand register, clear takes priority over load, and load takes priority over shift. Shifting brings in a 0 at the bottom.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request (low then high) |
| value_i | input | 26 | Unsigned operand |
| digits_o | output | 28 | Four 7-bit base-100 digits, most significant digit at the top |
| done_o | output | 1 | High when idle, low while converting |
| state_o | output | 3 | Debug view of the controller state |
| count_o | output | 5 | Debug view of the bit counter |

## Verification
The assertions assume two things. First, value_i is held steady from the accepted start until the operand is loaded. Second, the operand always fits in the digit chain, so nothing carries out of the top cell. The stimulus changes value_i only while done_o is high, and only before it starts a new request. Every operand it drives, including the 26-bit maximum, is within the input width. Start pulses are driven during conversions on purpose, to show that they are ignored, and reset is asserted in the middle of one conversion.

// File: rtl/b100_pkg.sv
package b100_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARM   = 3'd1,
      ST_CLEAR = 3'd2,
      ST_LOAD  = 3'd3,
      ST_SHIFT = 3'd4
   } conv_state_e;

   // True when base**digits can represent every in_w-bit value.
   function automatic bit radix_covers(input int base, input int digits, input int in_w);
      longint cap;
      longint lim;
      cap = 1;
      lim = longint'(1) << in_w;
      for (int i = 0; i < digits; i++) begin
         if (cap < lim) cap = cap * base;
      end
      return cap >= lim;
   endfunction

endpackage

// File: rtl/b100_cell.sv
module b100_cell #(
   parameter int CELL_W = 7,
   parameter int BASE   = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic              shin,
   output logic [CELL_W-1:0] q,
   output logic              shout
);
   localparam int HALF = BASE / 2;
   localparam int ADJ  = ((1 << CELL_W) - BASE) / 2;

   logic [CELL_W-1:0] adj;

   always_comb begin
      adj   = (q >= CELL_W'(HALF)) ? q + CELL_W'(ADJ) : q;
      shout = adj[CELL_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (shift) q <= {adj[CELL_W-2:0], shin};
   end

   AST_CELL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      q <= CELL_W'(BASE - 1)); // R3
   AST_CELL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == '0); // R5
   AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !shift) |=> $stable(q)); // R9

endmodule

// File: rtl/b100_opreg.sv
module b100_opreg #(
   parameter int W = 26
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         msb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (load)  q <= d;
      else if (shift) q <= {q[W-2:0], 1'b0};
   end

   assign msb = q[W-1];

   AST_OPR_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == '0); // R10
   AST_OPR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> q == $past(d)); // R10

endmodule

// File: rtl/b100_bitcnt.sv
module b100_bitcnt #(
   parameter int W      = 5,
   parameter int PRESET = 25
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         preset,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (preset)            cnt <= W'(PRESET);
      else if (en && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   AST_CNT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> cnt == W'(PRESET)); // R6
   AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !preset && zero) |=> zero); // R6

endmodule

// File: rtl/b100_conv.sv
module b100_conv
   import b100_pkg::*;
#(
   parameter int IN_W   = 26,
   parameter int DIGITS = 4,
   parameter int CELL_W = 7,
   parameter int BASE   = 100
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [IN_W-1:0]          value_i,
   output logic [DIGITS*CELL_W-1:0] digits_o,
   output logic                     done_o,
   output logic [2:0]               state_o,
   output logic [$clog2(IN_W)-1:0]  count_o
);
   localparam int DIG_W  = DIGITS * CELL_W;
   localparam int CNT_W  = $clog2(IN_W);
   localparam int PRESET = IN_W - 1;

   generate
      if ((BASE % 2) != 0 || BASE > (1 << CELL_W) || CELL_W < 2)
         begin : g_bad_base
            $error("b100_conv: BASE must be even and fit in CELL_W bits");
         end
      if (!radix_covers(BASE, DIGITS, IN_W))
         begin : g_bad_digits
            $error("b100_conv: DIGITS too few for IN_W");
         end
   endgenerate

   conv_state_e state_q, state_d;
   logic clr_en, load_en, shift_en, cnt_zero, any_set, op_msb;
   logic [IN_W-1:0] op_q;
   logic [DIGITS:0] link;

   assign clr_en   = (state_q == ST_CLEAR);
   assign load_en  = (state_q == ST_LOAD);
   assign shift_en = (state_q == ST_SHIFT);

   b100_opreg #(.W(IN_W)) u_opreg (
      .clk(clk), .rst_n(rst_n), .clr(clr_en), .load(load_en),
      .shift(shift_en), .d(value_i), .q(op_q), .msb(op_msb)
   );

   assign link[0] = op_msb;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_cell
         b100_cell #(.CELL_W(CELL_W), .BASE(BASE)) u_cell (
            .clk(clk), .rst_n(rst_n), .clr(clr_en), .shift(shift_en),
            .shin(link[g]), .q(digits_o[g*CELL_W +: CELL_W]), .shout(link[g+1])
         );
      end
   endgenerate

   b100_bitcnt #(.W(CNT_W), .PRESET(PRESET)) u_cnt (
      .clk(clk), .rst_n(rst_n), .preset(clr_en), .en(shift_en),
      .cnt(count_o), .zero(cnt_zero)
   );

   assign any_set = (|op_q) | (|digits_o);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (!start_i) state_d = ST_ARM;
         ST_ARM:   if (start_i)  state_d = ST_CLEAR;
         ST_CLEAR: if (!any_set) state_d = ST_LOAD;
         ST_LOAD:                state_d = ST_SHIFT;
         ST_SHIFT: if (cnt_zero) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign done_o  = (state_q == ST_IDLE) || (state_q == ST_ARM);
   assign state_o = state_q;

   AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_o) |-> ($past(start_i) && $past(state_q) == ST_ARM)); // R4
   AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> count_o == '0); // R6
   AST_DIGITS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(done_o)) |-> $stable(digits_o)); // R9
   AST_NO_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> !link[DIGITS]); // R2
   AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !any_set); // R5

   logic unused_width;
   assign unused_width = ^{DIG_W{1'b0}};

endmodule

// File: tb/test_b100_conv.sv
module test_b100_conv;
   localparam int CLK_PERIOD = 10;
   localparam int IN_W = 26;
   localparam int DIG_W = 28;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b1;
   logic [IN_W-1:0]   value_i = '0;
   logic [DIG_W-1:0]  digits_o;
   logic              done_o;
   logic [2:0]        state_o;
   logic [4:0]        count_o;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   b100_conv i_b100_conv (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
      .digits_o(digits_o), .done_o(done_o), .state_o(state_o), .count_o(count_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model: 0 idle, 1 armed, 2 busy
   int             m_state = 0;
   int             busy_left = 0;
   bit             prev_nz = 0;
   logic [DIG_W-1:0] exp_dig = '0;

   function automatic logic [DIG_W-1:0] to_b100(input longint v);
      logic [DIG_W-1:0] r;
      longint t;
      t = v;
      r = '0;
      for (int k = 0; k < 4; k++) begin
         r[k*7 +: 7] = 7'(t % 100);
         t = t / 100;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_state = 0; busy_left = 0; prev_nz = 0; exp_dig = '0;
      end else begin
         case (m_state)
            0: if (!start_i) m_state = 1;
            1: if (start_i) begin
                  m_state = 2;
                  busy_left = (prev_nz ? 2 : 1) + 27; // R5 R7
               end
            default: begin
               busy_left--;
               if (busy_left == 0) begin
                  m_state = 0;
                  exp_dig = to_b100(longint'(value_i));
                  prev_nz = (value_i != 0);
               end
            end
         endcase
      end
   end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (m_state == 2) begin
            check(done_o == 1'b0, "R7", "done low while busy", done_o, 0);
            if (busy_left <= 26)
               check(count_o == 5'(busy_left - 1), "R6", "counter while shifting",
                     count_o, busy_left - 1);
         end else begin
            check(done_o == 1'b1, "R7", "done high when idle", done_o, 1);
            check(digits_o == exp_dig, "R2", "digits", digits_o, exp_dig);
            check(count_o == 5'd0, "R6", "counter at rest", count_o, 0);
            check(state_o == 3'(m_state), "R4", "idle/armed state", state_o, m_state);
         end
      end
   end

   task automatic convert(input logic [IN_W-1:0] v);
      @(negedge clk);
      value_i = v;
      start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 100 && !done_o; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(done_o == 1'b1, "R1", "done in reset", done_o, 1);
      check(digits_o == '0, "R1", "digits in reset", digits_o, 0);
      check(count_o == 5'd0, "R1", "count in reset", count_o, 0);
      check(state_o == 3'd0, "R1", "state in reset", state_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: start held high never starts
      repeat (10) @(negedge clk);
      check(done_o == 1'b1, "R4", "no start without low phase", done_o, 1);

      convert(26'd11347559);                     // R2 worked example
      check(digits_o == {7'd11, 7'd34, 7'd75, 7'd59}, "R2", "11347559",
            digits_o, {7'd11, 7'd34, 7'd75, 7'd59});
      convert(26'd0);                            // R5 clearing with content
      convert(26'd0);                            // R5 clearing already zero
      convert(26'h3FFFFFF);                      // R3 largest operand
      check(digits_o == {7'd67, 7'd10, 7'd88, 7'd63}, "R3", "max operand",
            digits_o, {7'd67, 7'd10, 7'd88, 7'd63});
      convert(26'd49);
      convert(26'd50);
      convert(26'd99);
      convert(26'd100);
      convert(26'd10111213);
      convert(26'd9999999);

      begin
         logic [31:0] lcg;
         lcg = 32'h1234_5678;
         for (int i = 0; i < 8; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            convert(lcg[31:6]);
         end
      end

      // R8: start toggling during a conversion is ignored
      @(negedge clk);
      value_i = 26'd2468013;
      start_i = 1'b0;
      @(negedge clk); start_i = 1'b1;
      repeat (6) @(negedge clk); start_i = 1'b0;
      @(negedge clk); start_i = 1'b1;
      repeat (4) @(negedge clk); start_i = 1'b0;
      repeat (3) @(negedge clk); start_i = 1'b1;
      for (int i = 0; i < 100 && !done_o; i++) @(negedge clk);
      #1;
      check(digits_o == to_b100(2468013), "R8", "result after ignored starts",
            digits_o, to_b100(2468013));

      // R9: operand changes while done is high leave digits untouched
      repeat (3) @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         value_i = 26'(i * 1000003 + 7);
         @(negedge clk);
         #1;
         check(digits_o == to_b100(2468013), "R9", "digits hold",
               digits_o, to_b100(2468013));
      end

      // R1: reset in the middle of a conversion
      @(negedge clk);
      value_i = 26'd55555;
      start_i = 1'b0;
      @(negedge clk); start_i = 1'b1;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      check(digits_o == '0 && done_o, "R1", "reset mid conversion", digits_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      convert(26'd55555);
      check(digits_o == to_b100(55555), "R2", "after reset", digits_o, to_b100(55555));

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      wait (cycles >= 200000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule